// File: doc/BRIEF.md
# Interrupt and Reset Input Conditioner

This block sits between the asynchronous control pins of a small processor core and the core's sequencer. The maskable request, the non-maskable request, the wait-test line and the external reset each pass through a multi-flop synchronizer before any logic sees them. A low-to-high transition of the synchronized non-maskable line is captured as a pending request, so a short pulse is not lost. The maskable line is a level and is read only when the core marks an instruction boundary, gated by the core's interrupt-enable flag.

At every boundary strobe the block gives a combinational take/no-take decision. When the non-maskable request wins, the block also gives a fixed vector type. The vector of a maskable request comes later from the acknowledge cycles, which are outside this block. The external reset is qualified: only a synchronized pulse that stays high for a minimum run of clocks drives the core reset, and the core reset drops as soon as the synchronized line falls. A wait-stall output holds the core idle while it runs a wait instruction and the synchronized test line is high.

Top module: `irq_rst_cond`

## Requirements
- R1: Each asynchronous input (`intr_async`, `nmi_async`, `test_async`, `reset_async`) affects the outputs only after SYNC_STAGES (default 2) rising clock edges. A change driven before edge k is first visible after edge k+SYNC_STAGES-1.
- R2: With the synchronized maskable line high, `int_enable` high, no non-maskable request pending and `insn_boundary` high, the outputs are `irq_take`=1, `irq_nmi`=0 and `irq_type`=0.
- R3: While `int_enable` is low, a high maskable line never raises `irq_take`.
- R4: `irq_take` is never high while `insn_boundary` is low, whatever the request lines do.
- R5: A rising edge of the synchronized non-maskable line stays pending until the next boundary. There it gives `irq_take`=1, `irq_nmi`=1 and `irq_type`=NMI_TYPE (default 2), even when `int_enable` is low.
- R6: A pending non-maskable request clears on the clock edge at which it is taken. Keeping the line high afterwards raises no further request.
- R7: When a non-maskable request and an enabled maskable request meet at the same boundary, the non-maskable one is taken first. The maskable one is taken at a later boundary.
- R8: `core_reset` rises only after the synchronized reset line has been sampled high on MIN_RST (default 4) consecutive edges. A raw pulse held for fewer than MIN_RST clocks leaves `core_reset` low.
- R9: `core_reset` falls on the first edge that samples the synchronized reset line low.
- R10: While `core_reset` is high, no request is taken, and any pending non-maskable request is cleared.
- R11: `wait_stall` is high exactly when `wait_active` is high, the synchronized test line is high and `core_reset` is low.
- R12: While `por_n` is low, every output is low and all synchronizer and request state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Power-on reset of the block's own flops, active low, asynchronous |
| intr_async | input | 1 | Maskable request, level, asynchronous |
| nmi_async | input | 1 | Non-maskable request, rising edge, asynchronous |
| test_async | input | 1 | Wait-test line, asynchronous |
| reset_async | input | 1 | External reset request, asynchronous |
| int_enable | input | 1 | Core interrupt-enable flag |
| insn_boundary | input | 1 | High during the last clock of an instruction |
| wait_active | input | 1 | Core is executing a wait instruction |
| irq_take | output | 1 | Interrupt taken at this boundary |
| irq_nmi | output | 1 | The taken request is the non-maskable one |
| irq_type | output | TYPE_W | NMI_TYPE for a non-maskable take, zero otherwise |
| core_reset | output | 1 | Qualified reset to the core |
| wait_stall | output | 1 | Hold the core idle in a wait instruction |

## Verification
The checker holds several rules on every cycle: a take only at a boundary, a maskable take only when enabled, the non-maskable type and its priority, the minimum run before reset rises, release one edge after the line falls, and the clearing of the pending request under reset. Only the bench's scenarios can show the things that need a cause and a later effect. These are the exact synchronizer latency, that a short pulse is latched and later taken, that a held line gives one request only, that a short reset pulse is ignored, and that a request pending before reset does not come back afterwards.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   // Bit positions of the conditioned inputs inside the synchronizer bundle
   typedef enum logic [1:0] {
      SRC_INTR = 2'd0,
      SRC_NMI  = 2'd1,
      SRC_TEST = 2'd2,
      SRC_RST  = 2'd3
   } src_idx_e;

   localparam int unsigned N_SRC        = 4;
   localparam int unsigned DEF_SYNC     = 2;
   localparam int unsigned DEF_MIN_RST  = 4;
   localparam int unsigned DEF_TYPE_W   = 8;
   localparam int unsigned DEF_NMI_TYPE = 2;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) stg[0] <= '0;
      else        stg[0] <= din;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) stg[s] <= '0;
         else        stg[s] <= stg[s-1];
      end
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/irqc_rst_qual.sv
module irqc_rst_qual #(
   parameter int unsigned MIN_RST = 4
) (
   input  logic clk,
   input  logic por_n,
   input  logic rst_s,
   output logic rst_q
);
   localparam int unsigned CW  = $clog2(MIN_RST);
   localparam logic [CW-1:0] TOP = CW'(MIN_RST - 1);

   logic [CW-1:0] run;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         run   <= '0;
         rst_q <= 1'b0;
      end else begin
         if (!rst_s)          run <= '0;
         else if (run != TOP) run <= run + 1'b1;
         rst_q <= rst_s && (rst_q || run == TOP);
      end
   end
endmodule

// File: rtl/irqc_nmi_latch.sv
module irqc_nmi_latch (
   input  logic clk,
   input  logic por_n,
   input  logic nmi_s,
   input  logic flush,
   input  logic taken,
   output logic pend,
   output logic rise
);
   logic prev;

   assign rise = nmi_s && !prev;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         prev <= 1'b0;
         pend <= 1'b0;
      end else begin
         prev <= nmi_s;
         if (flush)      pend <= 1'b0;
         else if (rise)  pend <= 1'b1;
         else if (taken) pend <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_rst_cond.sv
module irq_rst_cond #(
   parameter int unsigned SYNC_STAGES = irqc_pkg::DEF_SYNC,
   parameter int unsigned MIN_RST     = irqc_pkg::DEF_MIN_RST,
   parameter int unsigned TYPE_W      = irqc_pkg::DEF_TYPE_W,
   parameter int unsigned NMI_TYPE    = irqc_pkg::DEF_NMI_TYPE
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              intr_async,
   input  logic              nmi_async,
   input  logic              test_async,
   input  logic              reset_async,
   input  logic              int_enable,
   input  logic              insn_boundary,
   input  logic              wait_active,
   output logic              irq_take,
   output logic              irq_nmi,
   output logic [TYPE_W-1:0] irq_type,
   output logic              core_reset,
   output logic              wait_stall
);
   import irqc_pkg::*;

   localparam logic [TYPE_W-1:0] NMI_VEC = TYPE_W'(NMI_TYPE);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (MIN_RST < 2) begin : g_bad_rst
      $error("MIN_RST must be at least 2");
   end
   if (TYPE_W < 2 || TYPE_W > 16) begin : g_bad_tw
      $error("TYPE_W out of range");
   end

   logic [N_SRC-1:0] raw_bus, syn_bus;
   logic intr_s, nmi_s, test_s, rst_s;
   logic nmi_pend, nmi_rise, live;

   always_comb begin
      raw_bus           = '0;
      raw_bus[SRC_INTR] = intr_async;
      raw_bus[SRC_NMI]  = nmi_async;
      raw_bus[SRC_TEST] = test_async;
      raw_bus[SRC_RST]  = reset_async;
   end

   irqc_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .por_n(por_n), .din(raw_bus), .dout(syn_bus)
   );

   assign intr_s = syn_bus[SRC_INTR];
   assign nmi_s  = syn_bus[SRC_NMI];
   assign test_s = syn_bus[SRC_TEST];
   assign rst_s  = syn_bus[SRC_RST];

   irqc_rst_qual #(.MIN_RST(MIN_RST)) u_rstq (
      .clk(clk), .por_n(por_n), .rst_s(rst_s), .rst_q(core_reset)
   );

   assign live = insn_boundary && !core_reset;

   irqc_nmi_latch u_nmi (
      .clk(clk), .por_n(por_n), .nmi_s(nmi_s), .flush(core_reset),
      .taken(live && nmi_pend), .pend(nmi_pend), .rise(nmi_rise)
   );

   always_comb begin
      irq_nmi  = live && nmi_pend;
      irq_take = irq_nmi || (live && intr_s && int_enable);
      irq_type = irq_nmi ? NMI_VEC : '0;
   end

   assign wait_stall = wait_active && test_s && !core_reset;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
   parameter int unsigned MIN_RST  = 4,
   parameter int unsigned TYPE_W   = 8,
   parameter int unsigned NMI_TYPE = 2
) (
   input logic              clk,
   input logic              por_n,
   input logic              int_enable,
   input logic              insn_boundary,
   input logic              wait_active,
   input logic              irq_take,
   input logic              irq_nmi,
   input logic [TYPE_W-1:0] irq_type,
   input logic              core_reset,
   input logic              wait_stall,
   input logic              reset_sync,
   input logic              nmi_pend
);
   localparam int unsigned RW = $clog2(MIN_RST + 1);
   localparam logic [RW-1:0] SAT = RW'(MIN_RST);

   logic [RW-1:0] hi_run;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)          hi_run <= '0;
      else if (!reset_sync) hi_run <= '0;
      else if (hi_run != SAT) hi_run <= hi_run + 1'b1;
   end

   p_take_at_bnd_r4: assert property (@(posedge clk) disable iff (!por_n)
      irq_take |-> insn_boundary);
   p_mask_r3: assert property (@(posedge clk) disable iff (!por_n)
      (irq_take && !irq_nmi) |-> int_enable);
   p_nmi_vec_r5: assert property (@(posedge clk) disable iff (!por_n)
      irq_nmi |-> (irq_take && irq_type == TYPE_W'(NMI_TYPE)));
   p_nmi_prio_r7: assert property (@(posedge clk) disable iff (!por_n)
      (insn_boundary && nmi_pend && !core_reset) |-> irq_nmi);
   p_rst_len_r8: assert property (@(posedge clk) disable iff (!por_n)
      $rose(core_reset) |-> (hi_run >= SAT));
   p_rst_rel_r9: assert property (@(posedge clk) disable iff (!por_n)
      (core_reset && !reset_sync) |=> !core_reset);
   p_rst_flush_r10: assert property (@(posedge clk) disable iff (!por_n)
      core_reset |=> !nmi_pend);
   p_rst_block_r10: assert property (@(posedge clk) disable iff (!por_n)
      core_reset |-> !irq_take);
   p_stall_r11: assert property (@(posedge clk) disable iff (!por_n)
      wait_stall |-> (wait_active && !core_reset));
endmodule

bind irq_rst_cond irqc_chk #(
   .MIN_RST(MIN_RST), .TYPE_W(TYPE_W), .NMI_TYPE(NMI_TYPE)
) u_chk (
   .clk(clk), .por_n(por_n), .int_enable(int_enable),
   .insn_boundary(insn_boundary), .wait_active(wait_active),
   .irq_take(irq_take), .irq_nmi(irq_nmi), .irq_type(irq_type),
   .core_reset(core_reset), .wait_stall(wait_stall),
   .reset_sync(rst_s), .nmi_pend(nmi_pend)
);

// File: tb/tb_irq_rst_cond.sv
`timescale 1ns/1ps
module tb_irq_rst_cond;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic por_n = 1'b0;
   logic intr_a = 0, nmi_a = 0, test_a = 0, rst_a = 0;
   logic ien = 0, bnd = 0, wact = 0;
   logic take, nmi_o, core_rst, stall;
   logic [7:0] typ;

   irq_rst_cond dut (
      .clk(clk), .por_n(por_n), .intr_async(intr_a), .nmi_async(nmi_a),
      .test_async(test_a), .reset_async(rst_a), .int_enable(ien),
      .insn_boundary(bnd), .wait_active(wact), .irq_take(take),
      .irq_nmi(nmi_o), .irq_type(typ), .core_reset(core_rst),
      .wait_stall(stall)
   );

   int n_chk = 0, n_bad = 0;
   string cur_req = "R12";

   // Behavioural reference: two-entry delay queues and counters
   bit q_intr[$] = '{0, 0};
   bit q_nmi[$]  = '{0, 0};
   bit q_test[$] = '{0, 0};
   bit q_rst[$]  = '{0, 0};
   int  m_run = 0;
   bit  m_core = 0, m_pend = 0, m_prev = 0;

   always @(posedge clk) begin
      if (!por_n) begin
         q_intr = '{0, 0}; q_nmi = '{0, 0}; q_test = '{0, 0}; q_rst = '{0, 0};
         m_run = 0; m_core = 0; m_pend = 0; m_prev = 0;
      end else begin
         bit was_core, nmi_taken;
         was_core  = m_core;
         nmi_taken = bnd && !was_core && m_pend;
         if (was_core)                 m_pend = 0;
         else if (q_nmi[0] && !m_prev) m_pend = 1;
         else if (nmi_taken)           m_pend = 0;
         m_prev = q_nmi[0];
         m_run  = q_rst[0] ? m_run + 1 : 0;
         m_core = (m_run >= 4);
         void'(q_intr.pop_front()); q_intr.push_back(intr_a);
         void'(q_nmi.pop_front());  q_nmi.push_back(nmi_a);
         void'(q_test.pop_front()); q_test.push_back(test_a);
         void'(q_rst.pop_front());  q_rst.push_back(rst_a);
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Cycle-by-cycle comparison against the reference
   always @(negedge clk) begin
      if (por_n) begin
         bit e_nmi, e_take, e_stall;
         e_nmi   = bnd && !m_core && m_pend;
         e_take  = e_nmi || (bnd && !m_core && q_intr[0] && ien);
         e_stall = wact && q_test[0] && !m_core;
         chk(take == e_take, cur_req, "irq_take", int'(take), int'(e_take));
         chk(nmi_o == e_nmi, cur_req, "irq_nmi", int'(nmi_o), int'(e_nmi));
         chk(typ == (e_nmi ? 8'd2 : 8'd0), cur_req, "irq_type", int'(typ),
             e_nmi ? 2 : 0);
         chk(core_rst == m_core, cur_req, "core_reset", int'(core_rst), int'(m_core));
         chk(stall == e_stall, cur_req, "wait_stall", int'(stall), int'(e_stall));
      end
   end

   task automatic step(input int n = 1);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic pulse_bnd(input int e_take, input int e_nmi, input int e_typ,
                            input string req);
      bnd = 1'b1;
      @(negedge clk);
      chk(take == e_take[0], req, "boundary irq_take", int'(take), e_take);
      chk(nmi_o == e_nmi[0], req, "boundary irq_nmi", int'(nmi_o), e_nmi);
      chk(int'(typ) == e_typ, req, "boundary irq_type", int'(typ), e_typ);
      step();
      bnd = 1'b0;
   endtask

   initial begin
      // R12: power-on reset
      step(2);
      @(negedge clk);
      chk({take, nmi_o, core_rst, stall} == 4'b0 && typ == 8'd0, "R12",
          "outputs under por_n", int'({take, nmi_o, core_rst, stall}), 0);
      step();
      por_n = 1'b1;
      step(3);

      // R1: synchronizer latency on the maskable line
      cur_req = "R1";
      ien = 1; bnd = 1;
      intr_a = 1;
      @(negedge clk); chk(take == 0, "R1", "before edge 1", int'(take), 0);
      @(negedge clk); chk(take == 0, "R1", "after edge 1", int'(take), 0);
      @(negedge clk); chk(take == 1, "R1", "after edge 2", int'(take), 1);
      step(); bnd = 0;

      // R2: enabled maskable take
      cur_req = "R2";
      step(2);
      pulse_bnd(1, 0, 0, "R2");

      // R4: no take between boundaries
      cur_req = "R4";
      repeat (3) begin
         @(negedge clk); chk(take == 0, "R4", "no boundary", int'(take), 0);
      end
      step();

      // R3: masked
      cur_req = "R3";
      ien = 0;
      step();
      pulse_bnd(0, 0, 0, "R3");
      intr_a = 0;
      step(3);

      // R5: short non-maskable pulse latched, taken with IE low
      cur_req = "R5";
      nmi_a = 1; step(); nmi_a = 0;
      step(5);
      pulse_bnd(1, 1, 2, "R5");

      // R6: cleared on take; held line gives one request
      cur_req = "R6";
      step();
      pulse_bnd(0, 0, 0, "R6");
      nmi_a = 1; step(4);
      pulse_bnd(1, 1, 2, "R6");
      step(2);
      pulse_bnd(0, 0, 0, "R6");
      nmi_a = 0; step(3);

      // R7: priority
      cur_req = "R7";
      ien = 1; intr_a = 1; nmi_a = 1; step(4);
      pulse_bnd(1, 1, 2, "R7");
      pulse_bnd(1, 0, 0, "R7");
      intr_a = 0; nmi_a = 0; ien = 0; step(3);

      // R8: short reset ignored
      cur_req = "R8";
      rst_a = 1; step(3); rst_a = 0;
      repeat (8) begin
         @(negedge clk); chk(core_rst == 0, "R8", "short pulse", int'(core_rst), 0);
      end
      step(2);

      // R8 and R9: minimum pulse accepted and released
      rst_a = 1; step(4); rst_a = 0;
      @(negedge clk);
      @(posedge clk); @(negedge clk);
      chk(core_rst == 0, "R8", "after edge 5", int'(core_rst), 0);
      @(posedge clk); @(negedge clk);
      chk(core_rst == 1, "R8", "after edge 6", int'(core_rst), 1);
      cur_req = "R9";
      @(posedge clk); @(negedge clk);
      chk(core_rst == 0, "R9", "after edge 7", int'(core_rst), 0);
      step(2);

      // R10: reset blocks takes and flushes a pending request
      cur_req = "R10";
      nmi_a = 1; step(); nmi_a = 0; step(3);
      rst_a = 1; ien = 1; intr_a = 1; step(8);
      pulse_bnd(0, 0, 0, "R10");
      rst_a = 0; intr_a = 0; step(4);
      pulse_bnd(0, 0, 0, "R10");

      // R11: wait stall
      cur_req = "R11";
      wact = 1; test_a = 1; step(2);
      @(negedge clk); chk(stall == 1, "R11", "test high", int'(stall), 1);
      step(); test_a = 0; step(2);
      @(negedge clk); chk(stall == 0, "R11", "test low", int'(stall), 0);
      step(); test_a = 1; wact = 0; step(2);
      @(negedge clk); chk(stall == 0, "R11", "not waiting", int'(stall), 0);
      step(2);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule